// File: doc/BRIEF.md
# Infrared Remote Pulse-Width Peripheral

This peripheral sits on a simple 16-bit register bus. In receive mode it watches an infrared input and measures the time between its edges. In transmit mode it generates a carrier waveform with programmable high and low sections. Both the carrier timing and the pulse measurement run from one free-running divider of the peripheral clock. Each path has its own 4-bit power-of-two select. Code n gives a ratio of 1/2^n, and the top code stops the path.

In receive mode the input passes through a synchronizer. Every rising or falling edge then does two things: it sets a sticky flag, and it restarts the length counter from zero. Software reads the counter at the next edge interrupt to learn the width of the pulse that just ended. A flag raises the interrupt request only while its enable bit is set. Software clears a flag by writing 1 to it.

Top module: `irpw_periph`

## Requirements
- R1: After reset all four registers read 0x0000, and `irq` and `carrier_out` are 0.
- R2: Register index 0 (settings) holds the carrier divide code in [15:12], the measure divide code in [11:8], the mode in bit 1 (1 = receive) and the enable in bit 0. Bits [7:2] always read 0, so writing 0xFFFF reads back 0xFF03.
- R3: In receive mode with the block enabled, a high-to-low change of `ir_in` sets bit 1 of register index 3. The flag is not visible two clocks after the input changes and is visible three clocks after.
- R4: Under the same conditions, a low-to-high change of `ir_in` sets bit 0 of register index 3 with the same latency.
- R5: Bits 8 (rise) and 9 (fall) of register index 3 are the enables. `irq` is 1 exactly when some flag and its own enable are both 1.
- R6: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R7: Each detected edge resets the length counter (register index 2) to 0. After that it adds one at every tick of the measure divider, so m clocks later it reads m / 2^n when the divide code n gives a multiple.
- R8: Divide code 0xF produces no ticks, so the length counter stays at 0.
- R9: The length counter saturates at 0xFFFF.
- R10: While the block is disabled or in transmit mode, input edges set no flag.
- R11: Register index 1 holds the carrier high length in [15:8] and the low length in [7:0]. When the block is enabled in transmit mode, `carrier_out` starts high. It then stays high for (high+1) carrier ticks and low for (low+1) ticks, and repeats. It is 0 in any other mode.
- R12: The length counter cannot be written from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 2 | Register index (byte offset divided by 2) |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the indexed register (combinational) |
| ir_in | input | 1 | Asynchronous infrared input |
| irq | output | 1 | Interrupt request |
| carrier_out | output | 1 | Carrier waveform in transmit mode |

## Verification
The bench builds the block with its defaults: a 14-bit divider and a two-stage synchronizer. With these, codes 0x0 to 0xE are real ratios and 0xF is the stop code. Pulse windows that are exact multiples of the tick period give exact counts, whatever the divider phase, for several codes. The 16-bit counter reaches saturation in about 65,540 clocks, which keeps the overflow case within a short run.

// File: rtl/irpw_periph.sv
module irpw_periph #(
  parameter int DIV_W  = 14,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_idx,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ir_in,
  output logic        irq,
  output logic        carrier_out
);

  localparam logic [3:0]  MAX_CODE  = 4'(DIV_W);
  localparam logic [15:0] SET_WMASK = 16'hFF03;
  localparam logic [15:0] INT_WMASK = 16'h0303;
  localparam logic [15:0] LCNT_MAX  = 16'hFFFF;

  logic [15:0]       set_q, car_q, lcnt_q;
  logic [1:0]        flg_q, ien_q;
  logic [DIV_W-1:0]  div_q;
  logic [SYNC_N-1:0] sync_q;
  logic              ir_prev;
  logic [7:0]        car_cnt;
  logic              car_hi;

  wire en     = set_q[0];
  wire rx_on  = set_q[0] &  set_q[1];
  wire tx_on  = set_q[0] & ~set_q[1];
  wire ir_s   = sync_q[SYNC_N-1];
  wire rise   = rx_on &  ir_s & ~ir_prev;
  wire fall   = rx_on & ~ir_s &  ir_prev;
  wire wr_set = reg_wr && (reg_idx == 2'd0);
  wire wr_car = reg_wr && (reg_idx == 2'd1);
  wire wr_int = reg_wr && (reg_idx == 2'd3);
  wire [15:0] int_w = reg_wdata & INT_WMASK;

  function automatic logic tick_of(input logic [3:0] code, input logic [DIV_W-1:0] cnt);
    logic [DIV_W-1:0] m;
    m = ~({DIV_W{1'b1}} << code);
    return (code <= MAX_CODE) && ((cnt & m) == m);
  endfunction

  wire lc_tick = en & tick_of(set_q[11:8], div_q);
  wire cg_tick = en & tick_of(set_q[15:12], div_q);
  wire [7:0] car_lim = car_hi ? car_q[15:8] : car_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      ir_prev <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_N-2:0], ir_in};
      ir_prev <= ir_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      car_q <= '0;
      ien_q <= '0;
      flg_q <= '0;
    end else begin
      if (wr_set) set_q <= reg_wdata & SET_WMASK;
      if (wr_car) car_q <= reg_wdata;
      if (wr_int) ien_q <= int_w[9:8];
      flg_q <= (flg_q & ~(wr_int ? int_w[1:0] : 2'b00)) | {fall, rise};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!en) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       lcnt_q <= '0;
    else if (rise || fall)                            lcnt_q <= '0;
    else if (rx_on && lc_tick && lcnt_q != LCNT_MAX)  lcnt_q <= lcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_cnt <= '0;
      car_hi  <= 1'b1;
    end else if (!tx_on) begin
      car_cnt <= '0;
      car_hi  <= 1'b1;
    end else if (cg_tick) begin
      if (car_cnt == car_lim) begin
        car_cnt <= '0;
        car_hi  <= ~car_hi;
      end else begin
        car_cnt <= car_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = set_q;
      2'd1:    reg_rdata = car_q;
      2'd2:    reg_rdata = lcnt_q;
      default: reg_rdata = {6'b0, ien_q, 6'b0, flg_q};
    endcase
  end

  assign irq         = |(flg_q & ien_q);
  assign carrier_out = tx_on & car_hi;

  assert_edge_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> (lcnt_q == 16'h0000));

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt_q == LCNT_MAX && !rise && !fall) |=> (lcnt_q == LCNT_MAX));

  assert_rise_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[0]) |-> $past(rx_on));

  assert_fall_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[1]) |-> $past(rx_on));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[1] && !wr_int) |=> flg_q[1]);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != 2'b00));

  assert_carrier_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_out |-> (en && !set_q[1]));

endmodule

// File: tb/irpw_periph_tb.sv
module irpw_periph_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ir_in = 1'b1;
  logic        irq, carrier_out;

  int nchecks = 0;
  int nerr = 0;

  // {divide code[31:28], pulse clocks[27:16], expected count[15:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {4'h0, 12'd5,  16'd5},
    {4'h1, 12'd10, 16'd5},
    {4'h2, 12'd40, 16'd10},
    {4'h3, 12'd16, 16'd2},
    {4'h0, 12'd1,  16'd1},
    {4'h4, 12'd48, 16'd3}
  };

  irpw_periph u_dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ir_in(ir_in),
    .irq(irq), .carrier_out(carrier_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchecks++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [15:0] v);
    reg_idx = idx;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    logic [15:0] v;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 reset register", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'd0);
    chk("R1 reset carrier", {15'd0, carrier_out}, 16'd0);

    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 reserved bits", v, 16'hFF03);
    wr(2'd0, 16'h0000);

    ir_in = 1'b0; wait_n(5); rd(2'd3, v); chk("R10 disabled edge", v, 16'h0000);
    ir_in = 1'b1; wait_n(5);
    wr(2'd0, 16'h0001);
    ir_in = 1'b0; wait_n(5); rd(2'd3, v); chk("R10 transmit edge", v, 16'h0000);
    ir_in = 1'b1; wait_n(5);
    wr(2'd0, 16'h0000);

    wr(2'd0, 16'h0003);
    ir_in = 1'b0; wait_n(2); rd(2'd3, v); chk("R3 latency not yet", v, 16'h0000);
    wait_n(1); rd(2'd3, v); chk("R3 fall flag", v, 16'h0002);
    chk("R5 irq masked", {15'd0, irq}, 16'd0);
    wr(2'd3, 16'h0200); rd(2'd3, v); chk("R5 enable readback", v, 16'h0202);
    chk("R5 irq on fall", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0100); chk("R5 wrong enable", {15'd0, irq}, 16'd0);
    wr(2'd3, 16'h0000); rd(2'd3, v); chk("R6 write 0 keeps", v, 16'h0002);
    wr(2'd3, 16'h0002); rd(2'd3, v); chk("R6 write 1 clears", v, 16'h0000);
    ir_in = 1'b1; wait_n(3); rd(2'd3, v); chk("R4 rise flag", v, 16'h0001);
    wr(2'd3, 16'h0100); chk("R5 irq on rise", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0001); rd(2'd3, v); chk("R6 clear rise", v, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      wr(2'd0, {4'h0, VEC[k][31:28], 8'h03});
      ir_in = ~ir_in;
      wait_n(3 + int'(VEC[k][27:16]));
      rd(2'd2, v); chk("R7 pulse width", v, VEC[k][15:0]);
      rd(2'd3, v);
      chk(ir_in ? "R4 table flag" : "R3 table flag", v, ir_in ? 16'h0001 : 16'h0002);
      wr(2'd3, 16'h0003);
    end

    wr(2'd0, 16'h0F03);
    ir_in = ~ir_in; wait_n(23);
    rd(2'd2, v); chk("R8 stop code", v, 16'h0000);
    wr(2'd3, 16'h0003);

    wr(2'd0, 16'h0003);
    ir_in = ~ir_in; wait_n(3 + 65540);
    rd(2'd2, v); chk("R9 saturation", v, 16'hFFFF);
    wr(2'd3, 16'h0003);

    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h1234);
    rd(2'd2, v); chk("R12 write ignored", v, 16'hFFFF);

    wr(2'd1, 16'h0201);
    rd(2'd1, v); chk("R11 carrier lengths", v, 16'h0201);
    wr(2'd0, 16'h0001);
    for (int i = 0; i < 10; i++) begin
      chk("R11 carrier wave", {15'd0, carrier_out}, ((i % 5) < 3) ? 16'd1 : 16'd0);
      @(negedge clk);
    end
    wr(2'd0, 16'h0003);
    chk("R11 carrier off in receive", {15'd0, carrier_out}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule